// File: doc/BRIEF.md
# Fractional-Period Block Sync Generator

This block turns a stream of accepted input samples into fixed-size data blocks. It frames every `BLOCK_SIZE` accepted samples as one block. The first sample of a block gets a start strobe and the last gets an end strobe. Each block is tagged with a sequence number. When generation is enabled, the sequence number is loaded from a start value, and it then rises by one per block.

Some blocks are marked with a sync flag on their first sample. The distance between syncs is given in samples by `SYNC_PERIOD`, and it need not divide evenly into blocks. The sync always lands on a block boundary. Most intervals span the integer quotient of the two parameters in blocks. A signed error accumulator decides which intervals are stretched by one block, so that over many intervals the mean sync spacing equals the requested sample count. The first block after enable always carries sync.

Dropping the enable stops output at once. Raising it again restarts framing from a fresh block, with a fresh sequence number and a fresh sync schedule.

Top module: `blk_sync_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs `o_valid`, `o_sop`, `o_eop` and `o_sync` are 0 after that edge.
- R2: `o_valid` is 1 exactly one cycle after a cycle in which `en` was 1, generation was already running, and `in_valid` was 1. An `in_valid` pulse while `en` is 0, or in the cycle that `en` first rises, produces no output.
- R3: Accepted samples are counted modulo `BLOCK_SIZE`, and idle cycles of `in_valid` do not break the count. `o_sop` is 1 on sample 0 of a block and `o_eop` is 1 on sample `BLOCK_SIZE-1`.
- R4: `o_bsn` is constant across all samples of a block. The first block after enable carries `start_bsn`, and every later block carries the previous block's value plus one.
- R5: `o_sync` is only ever 1 together with `o_sop` and `o_valid`.
- R6: The first block after generation is enabled, whose number equals `start_bsn`, carries sync.
- R7: When `SYNC_PERIOD % BLOCK_SIZE` is 0, sync occurs on exactly those blocks where (`o_bsn` − `start_bsn`) modulo `SYNC_PERIOD / BLOCK_SIZE` is 0.
- R8: When the leftover L = `SYNC_PERIOD % BLOCK_SIZE` is nonzero, the first interval spans M+1 blocks, where M = `SYNC_PERIOD / BLOCK_SIZE`, and an accumulator starts at `BLOCK_SIZE` − L. At every sync the accumulator loses L. If the result is negative, `BLOCK_SIZE` is added back and the next interval spans M+1 blocks; otherwise the next interval spans M blocks.
- R9: Lowering `en` mid-block discards the partial block. Raising `en` again restarts with sample 0, `o_bsn` = `start_bsn`, and sync on that first block.
- R10: The sync pattern depends only on the block offset from `start_bsn`, so a start value with nonzero upper bits (above bit 30) yields the same pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Generation enable; its rising edge loads the start number |
| start_bsn | input | BSN_W | Sequence number of the first block |
| in_valid | input | 1 | One input sample is present this cycle |
| o_valid | output | 1 | Output sample strobe |
| o_sop | output | 1 | First sample of a block |
| o_eop | output | 1 | Last sample of a block |
| o_sync | output | 1 | Sync mark on the first sample of a block |
| o_bsn | output | BSN_W | Sequence number of the current block |

## Verification
A corrupted sample counter shows as a misplaced `o_sop` or `o_eop` on the next output sample, and it also shifts `o_bsn`. A wrong interval counter or accumulator does not show at once. It is seen only at the next sync the model expects, or at a sync that appears early, which can be up to M+1 blocks later. For that reason every scenario runs over many sync intervals, and every block start is compared with an independent model of the accumulator rule. A wrong sequence register shows as a broken +1 step at the next block start.

// File: rtl/blk_sync_gen_pkg.sv
// Package: shared helpers for the block sync generator.
// Assumes: sizes come from elaboration-time parameters only.
package blk_sync_gen_pkg;

    // Width of a counter that must hold values 0..n-1 (at least 1 bit).
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Output strobes of one sample beat.
    typedef struct packed {
        logic valid;
        logic sop;
        logic eop;
        logic sync;
    } beat_t;

endpackage

// File: rtl/blk_framer.sv
// Module: blk_framer
// Counts accepted samples modulo BLOCK_SIZE and flags the first and last
// sample position of the block currently being built.
// Assumes: 'load' and 'adv' are never high in the same cycle.
module blk_framer
    import blk_sync_gen_pkg::*;
#(
    parameter int unsigned BLOCK_SIZE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic adv,
    output logic first,
    output logic last
);
    localparam int unsigned SW = cnt_width(BLOCK_SIZE);
    localparam logic [SW-1:0] LAST_IDX = SW'(BLOCK_SIZE - 1);

    logic [SW-1:0] pos_q;

    // Sample position within the block, wrapping after the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            pos_q <= '0;
        end else if (adv) begin
            if (pos_q == LAST_IDX) begin
                pos_q <= '0;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    assign first = (pos_q == '0);
    assign last  = (pos_q == LAST_IDX);

endmodule

// File: rtl/bsn_counter.sv
// Module: bsn_counter
// Holds the sequence number of the block being built. It loads the start
// value on 'load' and steps by one after the last sample of each block.
// Assumes: 'step' is only raised on the last sample of a block.
module bsn_counter #(
    parameter int unsigned BSN_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BSN_W-1:0] start_val,
    input  logic             step,
    output logic [BSN_W-1:0] bsn
);
    logic [BSN_W-1:0] bsn_q;

    // Load on enable, increment once per finished block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bsn_q <= '0;
        end else if (load) begin
            bsn_q <= start_val;
        end else if (step) begin
            bsn_q <= bsn_q + 1'b1;
        end
    end

    assign bsn = bsn_q;

endmodule

// File: rtl/sync_sched.sv
// Module: sync_sched
// Decides which block starts carry sync. A down-counter gives the blocks
// left until the next sync. When the period is not a whole number of
// blocks, a signed accumulator picks intervals one block longer.
// Assumes: SYNC_PERIOD >= BLOCK_SIZE; 'step' is raised once per block start.
module sync_sched
    import blk_sync_gen_pkg::*;
#(
    parameter int unsigned BLOCK_SIZE  = 4,
    parameter int unsigned SYNC_PERIOD = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step,
    output logic hit
);
    localparam int unsigned MIN_BLK = SYNC_PERIOD / BLOCK_SIZE;
    localparam int unsigned LEFTOVER = SYNC_PERIOD % BLOCK_SIZE;
    localparam int unsigned CW = cnt_width(MIN_BLK + 2);
    localparam int unsigned AW = cnt_width(BLOCK_SIZE) + 2;

    logic [CW-1:0] left_q;

    assign hit = (left_q == '0);

    generate
        if (LEFTOVER == 0) begin : g_whole
            // Whole-block period: fixed interval length, no accumulator.
            always_ff @(posedge clk) begin
                if (!rst_n || load) begin
                    left_q <= '0;
                end else if (step) begin
                    if (hit) begin
                        left_q <= CW'(MIN_BLK - 1);
                    end else begin
                        left_q <= left_q - 1'b1;
                    end
                end
            end
        end else begin : g_frac
            logic [CW-1:0]        len_q;
            logic signed [AW-1:0] acc_q;
            logic signed [AW-1:0] acc_dec;

            // Accumulator after removing this interval's leftover share.
            always_comb begin
                acc_dec = acc_q - $signed(AW'(LEFTOVER));
            end

            // Interval counter, next interval length and error accumulator.
            always_ff @(posedge clk) begin
                if (!rst_n || load) begin
                    left_q <= '0;
                    len_q  <= CW'(MIN_BLK + 1);
                    acc_q  <= $signed(AW'(BLOCK_SIZE - LEFTOVER));
                end else if (step) begin
                    if (hit) begin
                        left_q <= len_q - 1'b1;
                        if (acc_dec[AW-1]) begin
                            len_q <= CW'(MIN_BLK + 1);
                            acc_q <= acc_dec + $signed(AW'(BLOCK_SIZE));
                        end else begin
                            len_q <= CW'(MIN_BLK);
                            acc_q <= acc_dec;
                        end
                    end else begin
                        left_q <= left_q - 1'b1;
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/blk_sync_gen.sv
// Module: blk_sync_gen (top)
// Frames accepted samples into blocks of BLOCK_SIZE, numbers the blocks
// and marks block starts with sync every SYNC_PERIOD samples on average.
// All outputs are registered, one cycle after the accepted sample.
// Assumes: SYNC_PERIOD >= BLOCK_SIZE; en rising loads start_bsn.
module blk_sync_gen
    import blk_sync_gen_pkg::*;
#(
    parameter int unsigned BLOCK_SIZE  = 4,
    parameter int unsigned SYNC_PERIOD = 10,
    parameter int unsigned BSN_W       = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [BSN_W-1:0] start_bsn,
    input  logic             in_valid,
    output logic             o_valid,
    output logic             o_sop,
    output logic             o_eop,
    output logic             o_sync,
    output logic [BSN_W-1:0] o_bsn
);
    generate
        if (SYNC_PERIOD < BLOCK_SIZE) begin : g_bad_cfg
            $error("SYNC_PERIOD must cover at least one block");
        end
    endgenerate

    logic             running_q;
    logic             load;
    logic             adv;
    logic             first;
    logic             last;
    logic             hit;
    logic [BSN_W-1:0] cur_bsn;
    beat_t            beat_d;
    beat_t            beat_q;
    logic [BSN_W-1:0] bsn_q;

    assign load = en && !running_q;
    assign adv  = en && running_q && in_valid;

    // Run state: set the cycle after enable rises, cleared while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
        end else begin
            running_q <= en;
        end
    end

    blk_framer #(
        .BLOCK_SIZE(BLOCK_SIZE)
    ) u_framer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .adv  (adv),
        .first(first),
        .last (last)
    );

    bsn_counter #(
        .BSN_W(BSN_W)
    ) u_bsn (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .start_val(start_bsn),
        .step     (adv && last),
        .bsn      (cur_bsn)
    );

    sync_sched #(
        .BLOCK_SIZE (BLOCK_SIZE),
        .SYNC_PERIOD(SYNC_PERIOD)
    ) u_sched (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .step (adv && first),
        .hit  (hit)
    );

    // Strobes for the sample accepted this cycle.
    always_comb begin
        beat_d.valid = adv;
        beat_d.sop   = adv && first;
        beat_d.eop   = adv && last;
        beat_d.sync  = adv && first && hit;
    end

    // Output register: strobes follow each sample, the number holds between.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
            bsn_q  <= '0;
        end else begin
            beat_q <= beat_d;
            if (adv) begin
                bsn_q <= cur_bsn;
            end
        end
    end

    assign o_valid = beat_q.valid;
    assign o_sop   = beat_q.sop;
    assign o_eop   = beat_q.eop;
    assign o_sync  = beat_q.sync;
    assign o_bsn   = bsn_q;

endmodule

// File: rtl/blk_sync_gen_chk.sv
// Module: blk_sync_gen_chk
// Port-level checker bound to blk_sync_gen. It tracks the block number
// and the sync spacing seen at the outputs and checks them.
// Assumes: bound to every instance of the top module.
module blk_sync_gen_chk #(
    parameter int unsigned BLOCK_SIZE  = 4,
    parameter int unsigned SYNC_PERIOD = 10,
    parameter int unsigned BSN_W       = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             o_valid,
    input logic             o_sop,
    input logic             o_eop,
    input logic             o_sync,
    input logic [BSN_W-1:0] o_bsn
);
    localparam int unsigned MIN_BLK  = SYNC_PERIOD / BLOCK_SIZE;
    localparam bit          FRACTION = (SYNC_PERIOD % BLOCK_SIZE) != 0;

    logic [BSN_W-1:0] last_bsn;
    logic             after_eop;
    logic             first_pend;
    logic             have_sync;
    int unsigned      gap;

    // Observer state rebuilt from the outputs only.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            after_eop  <= 1'b0;
            first_pend <= 1'b1;
            have_sync  <= 1'b0;
            gap        <= 0;
            last_bsn   <= '0;
        end else if (o_valid) begin
            last_bsn <= o_bsn;
            if (o_eop) begin
                after_eop <= 1'b1;
            end else if (o_sop) begin
                after_eop <= 1'b0;
            end
            if (o_sop) begin
                first_pend <= 1'b0;
                if (o_sync) begin
                    have_sync <= 1'b1;
                    gap       <= 1;
                end else begin
                    gap <= gap + 1;
                end
            end
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!o_valid && !o_sop && !o_eop && !o_sync));

    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !o_valid);

    assert_marks_need_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (o_sop || o_eop) |-> o_valid);

    assert_bsn_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && o_valid && !o_sop) |-> (o_bsn == last_bsn));

    assert_bsn_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && o_valid && o_sop && after_eop) |-> (o_bsn == last_bsn + 1'b1));

    assert_sync_on_sop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        o_sync |-> (o_sop && o_valid));

    assert_first_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && o_valid && o_sop && first_pend) |-> o_sync);

    assert_sync_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && o_valid && o_sync && have_sync) |->
            ((gap == MIN_BLK) || (FRACTION && gap == MIN_BLK + 1)));

endmodule

bind blk_sync_gen blk_sync_gen_chk #(
    .BLOCK_SIZE (BLOCK_SIZE),
    .SYNC_PERIOD(SYNC_PERIOD),
    .BSN_W      (BSN_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .o_valid(o_valid),
    .o_sop  (o_sop),
    .o_eop  (o_eop),
    .o_sync (o_sync),
    .o_bsn  (o_bsn)
);

// File: tb/blk_sync_gen_tb.sv
`timescale 1ns/1ps
// Directed bench: a fractional-period instance (u_dut) and a whole-block
// instance (u_dut_int) share the stimulus. Each is compared every cycle
// with an independent model of the accumulator rule.
module blk_sync_gen_tb;
    localparam int BS0 = 4;
    localparam int SP0 = 10;
    localparam int BS1 = 4;
    localparam int SP1 = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [63:0] start_bsn = '0;
    logic        in_valid = 1'b0;

    logic        a_valid [2];
    logic        a_sop   [2];
    logic        a_eop   [2];
    logic        a_sync  [2];
    logic [63:0] a_bsn   [2];

    int errors = 0;
    int checks = 0;
    string scen = "R1";

    bit              m_run  [2];
    int              m_pos  [2];
    longint unsigned m_bsn  [2];
    longint unsigned m_start[2];
    bit              e_valid[2];
    bit              e_sop  [2];
    bit              e_eop  [2];
    bit              e_sync [2];
    longint unsigned e_bsn  [2];

    always #4 clk = ~clk;

    blk_sync_gen #(.BLOCK_SIZE(BS0), .SYNC_PERIOD(SP0), .BSN_W(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .start_bsn(start_bsn),
        .in_valid(in_valid), .o_valid(a_valid[0]), .o_sop(a_sop[0]),
        .o_eop(a_eop[0]), .o_sync(a_sync[0]), .o_bsn(a_bsn[0]));

    blk_sync_gen #(.BLOCK_SIZE(BS1), .SYNC_PERIOD(SP1), .BSN_W(64)) u_dut_int (
        .clk(clk), .rst_n(rst_n), .en(en), .start_bsn(start_bsn),
        .in_valid(in_valid), .o_valid(a_valid[1]), .o_sop(a_sop[1]),
        .o_eop(a_eop[1]), .o_sync(a_sync[1]), .o_bsn(a_bsn[1]));

    function automatic int bs_of(input int k);
        return (k == 0) ? BS0 : BS1;
    endfunction

    function automatic int sp_of(input int k);
        return (k == 0) ? SP0 : SP1;
    endfunction

    // Reference sync rule on the 31 low bits of the block number.
    function automatic bit ref_sync(input longint unsigned bsn,
                                    input longint unsigned st,
                                    input int bs, input int sp);
        int b;
        int s;
        int nmin;
        int lo;
        int nxt;
        int nblk;
        int acc;
        b = int'(bsn & 64'h7FFF_FFFF);
        s = int'(st & 64'h7FFF_FFFF);
        nmin = sp / bs;
        lo = sp % bs;
        if (b < s) return 1'b0;
        if (lo == 0) return ((b - s) % nmin) == 0;
        nxt = s;
        nblk = nmin + 1;
        acc = bs - lo;
        while (nxt < b) begin
            nxt = nxt + nblk;
            nblk = nmin;
            acc = acc - lo;
            if (acc < 0) begin
                nblk = nblk + 1;
                acc = acc + bs;
            end
        end
        return nxt == b;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] %s actual=%0h expected=%0h", req, scen, what, act, exp);
        end
    endtask

    // Model: expected outputs after the coming clock edge.
    task automatic model_update(input int k);
        e_valid[k] = 0; e_sop[k] = 0; e_eop[k] = 0; e_sync[k] = 0;
        if (!rst_n || !en) begin
            m_run[k] = 0;
        end else if (!m_run[k]) begin
            m_run[k] = 1;
            m_pos[k] = 0;
            m_bsn[k] = start_bsn;
            m_start[k] = start_bsn;
        end else if (in_valid) begin
            e_valid[k] = 1;
            e_sop[k] = (m_pos[k] == 0);
            e_eop[k] = (m_pos[k] == bs_of(k) - 1);
            e_sync[k] = e_sop[k] && ref_sync(m_bsn[k], m_start[k], bs_of(k), sp_of(k));
            e_bsn[k] = m_bsn[k];
            m_pos[k] = (m_pos[k] + 1) % bs_of(k);
            if (e_eop[k]) m_bsn[k] = m_bsn[k] + 1;
        end
    endtask

    task automatic compare(input int k);
        string syn_req;
        check(a_valid[k] == e_valid[k], rst_n ? "R2" : "R1", "valid", a_valid[k], e_valid[k]);
        check(a_sop[k] == e_sop[k], rst_n ? "R3" : "R1", "sop", a_sop[k], e_sop[k]);
        check(a_eop[k] == e_eop[k], rst_n ? "R3" : "R1", "eop", a_eop[k], e_eop[k]);
        if (e_valid[k]) begin
            check(a_bsn[k] == e_bsn[k], "R4", "bsn", a_bsn[k], e_bsn[k]);
        end
        if (e_sop[k] && e_bsn[k] == m_start[k]) syn_req = "R6";
        else syn_req = (k == 0) ? "R8" : "R7";
        check(a_sync[k] == e_sync[k], rst_n ? syn_req : "R1", "sync", a_sync[k], e_sync[k]);
        if (a_sync[k]) begin
            check(a_sop[k] && a_valid[k], "R5", "sync without sop", a_sop[k], 1);
        end
    endtask

    // One cycle: drive at the falling edge, check at the next falling edge.
    task automatic step(input bit v);
        in_valid = v;
        for (int k = 0; k < 2; k++) model_update(k);
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 2; k++) compare(k);
    endtask

    task automatic t_reset();
        scen = "R1";
        rst_n = 0; en = 1; in_valid = 1;
        for (int i = 0; i < 4; i++) step(1'b1);
        en = 0;
        step(1'b0);
        rst_n = 1;
        step(1'b0);
    endtask

    task automatic t_disabled_input();
        scen = "R2";
        en = 0;
        for (int i = 0; i < 6; i++) step(1'b1);
    endtask

    task automatic t_dense_zero_start();
        scen = "R7/R8 dense";
        start_bsn = 64'd0;
        en = 1;
        step(1'b1);
        for (int i = 0; i < 4 * 40; i++) step(1'b1);
        en = 0;
        step(1'b0);
    endtask

    task automatic t_gaps_high_start();
        scen = "R10 gaps";
        start_bsn = 64'hA5A5_0000_0000_0123;
        en = 1;
        step(1'b0);
        for (int i = 0; i < 180; i++) step((i % 3) != 2);
        en = 0;
        step(1'b0);
    endtask

    task automatic t_restart();
        scen = "R9 restart";
        start_bsn = 64'd7;
        en = 1;
        step(1'b0);
        for (int i = 0; i < 14; i++) step(1'b1);
        en = 0;
        step(1'b1);
        step(1'b1);
        start_bsn = 64'd40;
        en = 1;
        step(1'b1);
        for (int i = 0; i < 50; i++) step((i % 5) != 4);
        en = 0;
        step(1'b0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        for (int k = 0; k < 2; k++) begin
            m_run[k] = 0; m_pos[k] = 0; m_bsn[k] = 0; m_start[k] = 0;
            e_bsn[k] = 0;
        end
        @(negedge clk);
        t_reset();
        t_disabled_input();
        t_dense_zero_start();
        t_gaps_high_start();
        t_restart();
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 [%s] watchdog expired actual=%0d expected=%0d", scen, 1, 0);
        finish_run();
    end

endmodule